// File: doc/BRIEF.md
# MDIO Management Access Controller

This block lets a host read and write the management registers of external PHY devices over a two-wire serial bus, a clock (MDC) and a bidirectional data line (MDIO). The host programs two 32-bit registers through a simple write port. The control register holds an enable bit and the MDC divider, and it reports whether the frame engine is idle. The user-access register takes the operation, the PHY address, the register address and the write data in one word. The same register later returns the read data and an acknowledge flag.

A write to the user-access register with the go bit set starts one clause-22 frame. The go bit stays high while the frame is on the bus and clears itself when the last MDC period ends. On a read, the controller releases MDIO for the turnaround and the data phase. A PHY that pulls the line low in the second turnaround bit causes the acknowledge flag to be set.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the control register reads 0x800000FF: idle (bit 31) is 1, enable (bit 30) is 0 and the divider (bits 7:0) is 0xFF. The user-access register reads 0, MDC is low and `mdio_oe` is low.
- R2: User-access layout: go is bit 31, write/read (1 = write) is bit 30, acknowledge is bit 29, bits 28:26 read 0, the PHY register address is bits 25:21, the PHY address is bits 20:16 and data is bits 15:0. A write to this register with go = 1 while enabled starts a frame. From the next cycle go reads 1 and idle (control bit 31) reads 0.
- R3: A write frame drives, MSB first on MDIO: 32 ones, 01, opcode 01, the five PHY address bits, the five register bits, turnaround 10 and the 16 data bits. `mdio_oe` is high for all 64 bits, and MDIO changes only when MDC falls.
- R4: A read frame carries opcode 10 and has the same preamble, start and address fields. `mdio_oe` is low from the first turnaround bit (bit 46 of the frame) to the end of the frame.
- R5: On a read, the level of `mdio_i` is sampled at each rising MDC edge. A low level in the second turnaround bit sets acknowledge, and a high level clears it. The next 16 samples, MSB first, appear in the data field when go clears.
- R6: The MDC period is 2×(divider+1) system clocks, and the first rising MDC edge comes divider+1 clocks after go is seen set. Go reads 1 for exactly 128×(divider+1) cycles. It then clears on the same edge where MDC falls for the last time, and idle returns to 1.
- R7: A write to the user-access register while go reads 1 is ignored, including a write in the last busy cycle. The register fields are unchanged and no further frame starts.
- R8: While enable is 0, writes to the user-access register are ignored: go stays 0 and the register keeps its value.
- R9: The divider is captured when a frame starts. A control write during a frame changes the control register at once, but it does not change the running frame's MDC timing. Clearing enable during a frame lets that frame finish.
- R10: When a write frame completes, acknowledge reads 0 and the data field keeps the written value.
- R11: Between frames MDC is held low and MDIO is released (`mdio_oe` low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 user access |
| cfg_wdata | input | 32 | Register write data |
| ctrl_rdata | output | 32 | Control register contents (idle, enable, divider) |
| user_rdata | output | 32 | User-access register contents |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = controller drives) |
| mdio_i | input | 1 | MDIO input level |

## Verification
A host write to the user-access register can land in the same cycle in which the running frame completes and go self-clears. In that case the write must still be judged against the busy state and dropped. The bench provokes this by counting busy cycles and issuing a write with go set in exactly the last one. It then checks that the register holds the first frame's fields and result and that MDC stays quiet afterwards. A control write that disables the block and changes the divider in the middle of a frame is judged by the frame length: it must still match the divider captured at start.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    // User-access register bit positions
    localparam int UA_GO      = 31;
    localparam int UA_WRITE   = 30;
    localparam int UA_ACK     = 29;
    localparam int UA_RSV_HI  = 28;
    localparam int UA_RSV_LO  = 26;
    localparam int UA_REG_LSB = 21;
    localparam int UA_PHY_LSB = 16;

    // Control register bit positions
    localparam int CTRL_IDLE  = 31;
    localparam int CTRL_EN    = 30;

    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] data;
    } mdio_cmd_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t g_d, g_q;
    logic wrap;

    assign wrap = run && (g_q.cnt == div);

    always_comb begin
        g_d = g_q;
        if (!run) begin
            g_d.cnt = '0;
            g_d.mdc = 1'b0;
        end else if (wrap) begin
            g_d.cnt = '0;
            g_d.mdc = ~g_q.mdc;
        end else begin
            g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign mdc       = g_q.mdc;
    assign rise_tick = wrap && !g_q.mdc;
    assign fall_tick = wrap &&  g_q.mdc;

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam int FRAME_LEN  = PRE_LEN + 32;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] TA_FIRST   = IDX_W'(PRE_LEN + 14);
    localparam logic [IDX_W-1:0] TA_LAST    = IDX_W'(PRE_LEN + 15);
    localparam logic [IDX_W-1:0] DATA_FIRST = IDX_W'(PRE_LEN + 16);
    localparam logic [IDX_W-1:0] LAST_BIT   = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic                 busy;
        logic                 write;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_LEN-1:0] sh;
        logic [DATA_W-1:0]    rd;
        logic                 ack;
    } eng_t;

    eng_t e_d, e_q;
    logic [1:0] op_bits;
    logic [1:0] ta_bits;
    logic [DATA_W-1:0] wr_bits;

    assign op_bits = cmd.write ? 2'b01 : 2'b10;
    assign ta_bits = cmd.write ? 2'b10 : 2'b00;
    assign wr_bits = cmd.write ? cmd.data : '0;
    assign done    = e_q.busy && fall_tick && (e_q.idx == LAST_BIT);

    always_comb begin
        e_d = e_q;
        if (start && !e_q.busy) begin
            e_d.busy  = 1'b1;
            e_d.write = cmd.write;
            e_d.idx   = '0;
            e_d.sh    = {{PRE_LEN{1'b1}}, 2'b01, op_bits, cmd.phy, cmd.regad,
                         ta_bits, wr_bits};
            e_d.rd    = '0;
            e_d.ack   = 1'b0;
        end else if (e_q.busy) begin
            if (fall_tick) begin
                if (e_q.idx == LAST_BIT) begin
                    e_d.busy = 1'b0;
                end else begin
                    e_d.idx = e_q.idx + 1'b1;
                    e_d.sh  = {e_q.sh[FRAME_LEN-2:0], 1'b0};
                end
            end
            if (rise_tick && !e_q.write) begin
                if (e_q.idx == TA_LAST) begin
                    e_d.ack = ~mdio_i;
                end
                if (e_q.idx >= DATA_FIRST) begin
                    e_d.rd = {e_q.rd[DATA_W-2:0], mdio_i};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign busy    = e_q.busy;
    assign ack     = e_q.ack;
    assign rdata   = e_q.rd;
    assign mdio_o  = e_q.busy ? e_q.sh[FRAME_LEN-1] : 1'b1;
    assign mdio_oe = e_q.busy && (e_q.write || (e_q.idx < TA_FIRST));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 255,
    parameter int PRE_LEN   = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] ctrl_rdata,
    output logic [31:0] user_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    localparam int PAD_W = 30 - DIV_W;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] div_run;
        logic [31:0]      ua;
    } regs_t;

    regs_t r_d, r_q;

    logic              start;
    mdio_cmd_t         cmd;
    logic              eng_busy;
    logic              eng_done;
    logic              eng_ack;
    logic [DATA_W-1:0] eng_rdata;
    logic              rise_tick;
    logic              fall_tick;

    assign cmd.write = cfg_wdata[UA_WRITE];
    assign cmd.phy   = cfg_wdata[UA_PHY_LSB +: ADDR_W];
    assign cmd.regad = cfg_wdata[UA_REG_LSB +: ADDR_W];
    assign cmd.data  = cfg_wdata[DATA_W-1:0];

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        if (cfg_wr && !cfg_sel) begin
            r_d.en  = cfg_wdata[CTRL_EN];
            r_d.div = cfg_wdata[DIV_W-1:0];
        end
        if (cfg_wr && cfg_sel && r_q.en && !r_q.ua[UA_GO]) begin
            r_d.ua                     = cfg_wdata;
            r_d.ua[UA_ACK]             = 1'b0;
            r_d.ua[UA_RSV_HI:UA_RSV_LO] = '0;
            if (cfg_wdata[UA_GO]) begin
                start     = 1'b1;
                r_d.div_run = r_q.div;
            end
        end
        if (eng_done) begin
            r_d.ua[UA_GO] = 1'b0;
            if (!r_q.ua[UA_WRITE]) begin
                r_d.ua[UA_ACK]        = eng_ack;
                r_d.ua[DATA_W-1:0]    = eng_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.div     <= DIV_W'(DIV_RESET);
            r_q.div_run <= DIV_W'(DIV_RESET);
        end else begin
            r_q <= r_d;
        end
    end

    mdio_mdc_gen #(
        .DIV_W (DIV_W)
    ) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (eng_busy),
        .div       (r_q.div_run),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine #(
        .PRE_LEN (PRE_LEN)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (cmd),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (eng_busy),
        .done      (eng_done),
        .ack       (eng_ack),
        .rdata     (eng_rdata),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    assign ctrl_rdata = {~eng_busy, r_q.en, {PAD_W{1'b0}}, r_q.div};
    assign user_rdata = r_q.ua;

endmodule

// File: rtl/mdio_mgmt_ctrl_sva.sv
module mdio_mgmt_ctrl_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic        cfg_sel,
    input logic [31:0] ctrl_rdata,
    input logic [31:0] user_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);

    // R2: idle flag from the engine mirrors the go bit held in the register
    p_idle_matches_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[31] == !user_rdata[31]);

    // R11: no clock and no drive between frames
    p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !user_rdata[31] |-> (!mdc && !mdio_oe));

    // R7: a write while busy leaves the command fields alone
    p_busy_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel && user_rdata[31]) |=>
        (user_rdata[30] == $past(user_rdata[30]) &&
         user_rdata[25:16] == $past(user_rdata[25:16])));

    // R8: disabled block never starts a frame
    p_disabled_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel && !ctrl_rdata[30] && !user_rdata[31]) |=> !user_rdata[31]);

    // R3: MDIO only moves when MDC falls during a frame
    p_drive_change_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (user_rdata[31] && $past(user_rdata[31]) && !$fell(mdc)) |-> $stable(mdio_o));

    // R3: write frames keep the line driven
    p_write_full_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (user_rdata[31] && user_rdata[30]) |-> mdio_oe);

    // R6: go self-clears together with the final MDC fall
    p_go_clears_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(user_rdata[31]) |-> $fell(mdc));

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_sel    (cfg_sel),
    .ctrl_rdata (ctrl_rdata),
    .user_rdata (user_rdata),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
);

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic [31:0] user_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i_r = 1'b1;

    mdio_mgmt_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .ctrl_rdata (ctrl_rdata),
        .user_rdata (user_rdata),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .mdio_i     (mdio_i_r)
    );

    always #2 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // PHY model state
    bit          phy_respond = 1'b0;
    logic [15:0] phy_data = '0;
    logic [63:0] cap_bits = '0;
    logic [63:0] cap_oe = '0;
    int          fcnt = 0;
    int          rcnt = 0;
    logic        mdc_prev = 1'b0;

    // PHY: capture on MDC rise, drive after MDC fall; sampled away from clk rise
    always @(negedge clk) begin
        if (!user_rdata[31]) begin
            fcnt = 0;
            rcnt = 0;
            mdio_i_r = 1'b1;
        end else begin
            if (mdc && !mdc_prev && rcnt < 64) begin
                cap_bits[63-rcnt] = mdio_o;
                cap_oe[63-rcnt]   = mdio_oe;
                rcnt++;
            end
            if (!mdc && mdc_prev) begin
                fcnt++;
                if (fcnt == 47)
                    mdio_i_r = phy_respond ? 1'b0 : 1'b1;
                else if (fcnt >= 48 && fcnt <= 63)
                    mdio_i_r = phy_respond ? phy_data[63-fcnt] : 1'b1;
                else
                    mdio_i_r = 1'b1;
            end
        end
        mdc_prev = mdc;
    end

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input bit sel, input logic [31:0] d);
        @(negedge clk);
        cfg_sel   = sel;
        cfg_wdata = d;
        cfg_wr    = 1'b1;
        @(posedge clk);
        #1 cfg_wr = 1'b0;
    endtask

    function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
                (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0000)};
    endfunction

    int busy_cnt;
    int first_rise;
    int first_fall;

    task automatic run_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] d, input int inj_at,
                             input bit inj_sel, input logic [31:0] inj_d);
        cfg_write(1'b1, {1'b1, wr, 1'b0, 3'b000, rg, phy, d});
        busy_cnt   = 0;
        first_rise = -1;
        first_fall = -1;
        forever begin
            @(negedge clk);
            if (!user_rdata[31]) begin
                cfg_wr = 1'b0;
                break;
            end
            busy_cnt++;
            if (busy_cnt == 1)
                check(user_rdata[31] && !ctrl_rdata[31], "R2 go set and idle clear",
                      {32'h0, user_rdata}, {32'h0, ctrl_rdata});
            if (mdc && first_rise < 0) first_rise = busy_cnt;
            if (!mdc && first_rise >= 0 && first_fall < 0) first_fall = busy_cnt;
            if (busy_cnt == inj_at) begin
                cfg_sel   = inj_sel;
                cfg_wdata = inj_d;
                cfg_wr    = 1'b1;
            end else begin
                cfg_wr = 1'b0;
            end
            if (busy_cnt > 5000) begin
                check(1'b0, "R6 frame never ended", 64'(busy_cnt), 64'd0);
                cfg_wr = 1'b0;
                break;
            end
        end
    endtask

    task automatic frame_checks(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                                input logic [15:0] d, input int div);
        logic [63:0] ef;
        logic [31:0] eu;
        ef = exp_frame(wr, phy, rg, d);
        check(busy_cnt == 128 * (div + 1), "R6 busy length", 64'(busy_cnt), 64'(128 * (div + 1)));
        // go seen at count 1; MDC goes high div+1 cycles later
        check(first_rise == div + 2, "R6 first MDC rise", 64'(first_rise), 64'(div + 2));
        check(first_fall - first_rise == div + 1, "R6 MDC half period",
              64'(first_fall - first_rise), 64'(div + 1));
        if (wr) begin
            check(cap_bits == ef, "R3 write frame bits", cap_bits, ef);
            check(cap_oe == '1, "R3 write frame drive", cap_oe, '1);
            eu = {1'b0, 1'b1, 1'b0, 3'b000, rg, phy, d};
            check(user_rdata == eu, "R10 write result", {32'h0, user_rdata}, {32'h0, eu});
        end else begin
            check(cap_bits[63:18] == ef[63:18], "R4 read header bits",
                  {18'h0, cap_bits[63:18]}, {18'h0, ef[63:18]});
            check(cap_oe == {{46{1'b1}}, {18{1'b0}}}, "R4 read release", cap_oe,
                  {{46{1'b1}}, {18{1'b0}}});
            eu = {2'b00, phy_respond, 3'b000, rg, phy, (phy_respond ? phy_data : 16'hFFFF)};
            check(user_rdata == eu, "R5 read result", {32'h0, user_rdata}, {32'h0, eu});
        end
        check(ctrl_rdata[31] && !mdc && !mdio_oe, "R11 idle bus after frame",
              {61'h0, ctrl_rdata[31], mdc, mdio_oe}, 64'h4);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit quiet;
        logic [31:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(ctrl_rdata == 32'h8000_00FF, "R1 control reset", {32'h0, ctrl_rdata}, 64'h8000_00FF);
        check(user_rdata == 32'h0, "R1 user reset", {32'h0, user_rdata}, 64'h0);
        check(!mdc && !mdio_oe, "R1 bus reset", {62'h0, mdc, mdio_oe}, 64'h0);

        // R8: disabled block ignores a go write
        cfg_write(1'b1, 32'hC06B_1234);
        quiet = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (mdc || user_rdata[31]) quiet = 1'b0;
        end
        check(quiet && user_rdata == 32'h0, "R8 disabled write ignored",
              {32'h0, user_rdata}, 64'h0);

        // sweep of divider values and frame kinds
        for (int dv = 0; dv < 4; dv++) begin
            cfg_write(1'b0, 32'h4000_0000 | 32'(dv));
            check(ctrl_rdata == (32'hC000_0000 | 32'(dv)), "R2 control layout",
                  {32'h0, ctrl_rdata}, {32'h0, 32'hC000_0000 | 32'(dv)});
            run_frame(1'b1, 5'h01, 5'h1F, 16'hA5C3, -1, 1'b0, 32'h0);
            frame_checks(1'b1, 5'h01, 5'h1F, 16'hA5C3, dv);
            run_frame(1'b1, 5'h1E, 5'h00, 16'h5A3C ^ 16'(dv), -1, 1'b0, 32'h0);
            frame_checks(1'b1, 5'h1E, 5'h00, 16'h5A3C ^ 16'(dv), dv);
            phy_respond = 1'b1;
            phy_data    = 16'h8001 ^ 16'(dv << 4);
            run_frame(1'b0, 5'h03, 5'h02, 16'hFFFF, -1, 1'b0, 32'h0);
            frame_checks(1'b0, 5'h03, 5'h02, 16'hFFFF, dv);
            phy_respond = 1'b0;
            run_frame(1'b0, 5'h15, 5'h0A, 16'h0000, -1, 1'b0, 32'h0);
            frame_checks(1'b0, 5'h15, 5'h0A, 16'h0000, dv);
        end

        // R5: all PHY addresses with divider 0
        cfg_write(1'b0, 32'h4000_0000);
        for (int a = 0; a < 32; a++) begin
            phy_respond = (a % 3) != 0;
            phy_data    = 16'(a * 16'h0801) ^ 16'h1234;
            run_frame(1'b0, 5'(a), 5'(31 - a), 16'h0, -1, 1'b0, 32'h0);
            frame_checks(1'b0, 5'(a), 5'(31 - a), 16'h0, 0);
        end
        phy_respond = 1'b0;

        // R7: write in the middle of a frame
        cfg_write(1'b0, 32'h4000_0001);
        run_frame(1'b1, 5'h0A, 5'h15, 16'hBEEF, 10, 1'b1, 32'hC3FF_1234);
        frame_checks(1'b1, 5'h0A, 5'h15, 16'hBEEF, 1);
        check(user_rdata[25:16] == {5'h15, 5'h0A}, "R7 mid-frame write ignored",
              {54'h0, user_rdata[25:16]}, {54'h0, 5'h15, 5'h0A});

        // R7: write in the last busy cycle
        run_frame(1'b1, 5'h11, 5'h05, 16'h0F0F, 256, 1'b1, 32'hC3FF_4321);
        frame_checks(1'b1, 5'h11, 5'h05, 16'h0F0F, 1);
        held  = user_rdata;
        quiet = 1'b1;
        repeat (12) begin
            @(negedge clk);
            if (mdc || user_rdata[31]) quiet = 1'b0;
        end
        check(quiet && user_rdata == held, "R7 completion-cycle write ignored",
              {32'h0, user_rdata}, {32'h0, held});

        // R9: control write mid-frame (disable, divider 0)
        cfg_write(1'b0, 32'h4000_0002);
        phy_respond = 1'b1;
        phy_data    = 16'hC0DE;
        run_frame(1'b0, 5'h07, 5'h19, 16'h0, 50, 1'b0, 32'h0000_0000);
        frame_checks(1'b0, 5'h07, 5'h19, 16'h0, 2);
        check(ctrl_rdata == 32'h8000_0000, "R9 control updated mid-frame",
              {32'h0, ctrl_rdata}, 64'h8000_0000);

        // R8: disabled again, go write ignored
        held = user_rdata;
        cfg_write(1'b1, 32'hC000_5555);
        quiet = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (mdc || user_rdata[31]) quiet = 1'b0;
        end
        check(quiet && user_rdata == held, "R8 write ignored after disable",
              {32'h0, user_rdata}, {32'h0, held});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule